// File: doc/BRIEF.md
# Configurable 4-bit Microcontroller Port Unit

This unit is the I/O port section of a small 4-bit microcontroller core. It holds eight 4-bit R output latches and a 16-bit discrete D latch. It serves decoded requests from the core: write an R latch from the A or B register, drive a single D bit high or low, and load the status flag from one D bit. A D bit is chosen either by the Y register or by the low four opcode bits. Reading an R port is combinational and is meant for the core's load-A and load-B operations.

Two parameters shape the unit. `CMOS` selects the pin technology, which sets the reset values and the rule for merging pins with latches. `VARIANT` selects the family member (43, 44, 45, or any other value for unrestricted). It fixes which R indices accept writes, and whether the upper D lines are output-only.

Top module: `mcu_port_unit`

## Requirements
- R1: When reset (`rst_n` = 0) is released, every R latch holds 0xF and every D latch bit holds 1 with `CMOS` = 1. With `CMOS` = 0, all of them hold 0. The status flag holds 1 in both cases.
- R2: `r_rd` is a combinational read of R port `imm[2:0]`. It is the 4-bit pin nibble ANDed with the latch nibble when `CMOS` = 1, and ORed with it when `CMOS` = 0. The same rule applies to indices whose writes are ignored. R port k occupies bits 4k+3..4k of `r_pin` and `r_out`.
- R3: Request code 7 loads `status` with the merged read of D bit `y`, on the clock edge that samples the request. The merge is pin AND latch for CMOS and pin OR latch for PMOS.
- R4: Request code 1 sets, and code 2 clears, D latch bit `y` on the next edge. All other D bits are left unchanged.
- R5: Request code 3 sets, and code 4 clears, D latch bit `imm` on the next edge.
- R6: Request code 5 stores `acc`, and code 6 stores `breg`, into R latch `imm[2:0]` on the next edge, if that index accepts writes. Request code 0 changes no latch.
- R7: With `VARIANT` = 44, R indices 0 to 5 accept writes and indices 6 and 7 ignore them.
- R8: With `VARIANT` = 43, only R indices 1 to 3 accept writes. Indices 0 and 4 to 7 ignore them.
- R9: With `VARIANT` = 45, R indices 0 to 6 accept writes and index 7 ignores them.
- R10: An ignored write leaves every R latch unchanged. It raises `illegal_port_write` for exactly the one cycle following the request.
- R11: With `VARIANT` = 43, the read of D bits 4 to 15 used by code 7 returns the latch bit alone and ignores the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 3 | Request code: 0 idle, 1 set D[y], 2 clear D[y], 3 set D[imm], 4 clear D[imm], 5 R from A, 6 R from B, 7 test D[y] |
| imm | input | 4 | Low opcode bits: D index, or R index in bits 2..0 |
| y | input | 4 | Y register value |
| acc | input | 4 | A register value |
| breg | input | 4 | B register value |
| r_pin | input | 32 | External R pin levels |
| d_pin | input | 16 | External D pin levels |
| r_out | output | 32 | R output latches |
| d_out | output | 16 | D output latches |
| r_rd | output | 4 | Merged read of R port imm[2:0] |
| status | output | 1 | Status flag |
| illegal_port_write | output | 1 | Pulse for an ignored R write |

## Verification
The bench runs three configurations side by side: CMOS variant 44, PMOS variant 43 and CMOS variant 45. It writes every R index from both A and B. An off-by-one in any write mask therefore shows up either as a latch that changes when it should not, or as a missing or spurious `illegal_port_write` pulse. Every D bit is set, cleared and tested, both through Y and through the immediate, against pin patterns whose levels disagree with the latch. A swapped AND/OR merge, or variant 43 merging pins on D4 to D15, then gives a wrong status value. Reads of indices that ignore writes are checked too, to catch a design that forces them to a constant.

// File: rtl/mcu_port_unit.sv
module mcu_port_unit #(
  parameter bit CMOS    = 1'b1,
  parameter int VARIANT = 44,
  parameter int NR      = 8,
  parameter int RW      = 4,
  parameter int ND      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         req,
  input  logic [$clog2(ND)-1:0] imm,
  input  logic [$clog2(ND)-1:0] y,
  input  logic [RW-1:0]      acc,
  input  logic [RW-1:0]      breg,
  input  logic [NR*RW-1:0]   r_pin,
  input  logic [ND-1:0]      d_pin,
  output logic [NR*RW-1:0]   r_out,
  output logic [ND-1:0]      d_out,
  output logic [RW-1:0]      r_rd,
  output logic               status,
  output logic               illegal_port_write
);
  localparam int IW = $clog2(NR);

  function automatic logic [NR-1:0] write_mask();
    logic [NR-1:0] m;
    for (int i = 0; i < NR; i++) begin
      case (VARIANT)
        43:      m[i] = (i >= 1) && (i <= 3);
        44:      m[i] = (i <= 5);
        45:      m[i] = (i <= 6);
        default: m[i] = 1'b1;
      endcase
    end
    return m;
  endfunction

  function automatic logic [ND-1:0] pin_mask();
    logic [ND-1:0] m;
    for (int i = 0; i < ND; i++) m[i] = (VARIANT != 43) || (i < 4);
    return m;
  endfunction

  localparam logic [NR-1:0]    WMASK = write_mask();
  localparam logic [ND-1:0]    DMASK = pin_mask();
  localparam logic [NR*RW-1:0] R_RST = CMOS ? '1 : '0;
  localparam logic [ND-1:0]    D_RST = CMOS ? '1 : '0;

  logic [IW-1:0]    widx;
  logic [NR*RW-1:0] r_view;
  logic [ND-1:0]    d_view, d_eff;
  logic             wr_req;

  assign widx   = imm[IW-1:0];
  assign r_view = CMOS ? (r_pin & r_out) : (r_pin | r_out);
  assign r_rd   = r_view[widx*RW +: RW];
  assign d_view = CMOS ? (d_pin & d_out) : (d_pin | d_out);
  assign d_eff  = (d_view & DMASK) | (d_out & ~DMASK);
  assign wr_req = (req == 3'd5) || (req == 3'd6);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_out              <= R_RST;
      d_out              <= D_RST;
      status             <= 1'b1;
      illegal_port_write <= 1'b0;
    end else begin
      illegal_port_write <= wr_req && !WMASK[widx];
      case (req)
        3'd1: d_out[y]   <= 1'b1;
        3'd2: d_out[y]   <= 1'b0;
        3'd3: d_out[imm] <= 1'b1;
        3'd4: d_out[imm] <= 1'b0;
        3'd5: if (WMASK[widx]) r_out[widx*RW +: RW] <= acc;
        3'd6: if (WMASK[widx]) r_out[widx*RW +: RW] <= breg;
        3'd7: status <= d_eff[y];
        default: ;
      endcase
    end
  end
endmodule

module mcu_port_unit_chk #(
  parameter bit CMOS = 1'b1,
  parameter int NR   = 8,
  parameter int RW   = 4,
  parameter int ND   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         req,
  input logic [$clog2(ND)-1:0] imm,
  input logic [$clog2(ND)-1:0] y,
  input logic [NR*RW-1:0]   r_out,
  input logic [ND-1:0]      d_out,
  input logic               status,
  input logic               illegal_port_write
);
  localparam logic [NR*RW-1:0] R_RST = CMOS ? '1 : '0;
  localparam logic [ND-1:0]    D_RST = CMOS ? '1 : '0;

  assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (r_out == R_RST) && (d_out == D_RST) && status);

  assert_set_by_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 3'd1) |=> d_out[$past(y)]);

  assert_clear_by_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 3'd2) |=> !d_out[$past(y)]);

  assert_set_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 3'd3) |=> d_out[$past(imm)]);

  assert_clear_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 3'd4) |=> !d_out[$past(imm)]);

  assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req == 3'd0) |=> $stable(r_out) && $stable(d_out));

  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_port_write |-> (r_out == $past(r_out)) &&
      (($past(req) == 3'd5) || ($past(req) == 3'd6)));
endmodule

bind mcu_port_unit mcu_port_unit_chk #(.CMOS(CMOS), .NR(NR), .RW(RW), .ND(ND)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .imm(imm), .y(y), .r_out(r_out),
  .d_out(d_out), .status(status), .illegal_port_write(illegal_port_write));

// File: tb/sim_mcu_port_unit.sv
module sim_mcu_port_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [3:0] imm = '0, y = '0, acc = '0, breg = '0;
  logic [31:0] r_pin = '0;
  logic [15:0] d_pin = '0;

  logic [31:0] ro [3];
  logic [15:0] dq [3];
  logic [3:0]  rr [3];
  logic        st [3];
  logic        il [3];

  int nvec = 0;
  int nbad = 0;

  localparam bit CM [3] = '{1'b1, 1'b0, 1'b1};
  localparam int VR [3] = '{44, 43, 45};

  logic [3:0]  er [3][8];
  logic [15:0] ed [3];
  logic        es [3];
  logic        eil [3];

  always #4 clk = ~clk;

  mcu_port_unit #(.CMOS(1'b1), .VARIANT(44)) u0 (.clk(clk), .rst_n(rst_n), .req(req),
    .imm(imm), .y(y), .acc(acc), .breg(breg), .r_pin(r_pin), .d_pin(d_pin),
    .r_out(ro[0]), .d_out(dq[0]), .r_rd(rr[0]), .status(st[0]), .illegal_port_write(il[0]));
  mcu_port_unit #(.CMOS(1'b0), .VARIANT(43)) u1 (.clk(clk), .rst_n(rst_n), .req(req),
    .imm(imm), .y(y), .acc(acc), .breg(breg), .r_pin(r_pin), .d_pin(d_pin),
    .r_out(ro[1]), .d_out(dq[1]), .r_rd(rr[1]), .status(st[1]), .illegal_port_write(il[1]));
  mcu_port_unit #(.CMOS(1'b1), .VARIANT(45)) u2 (.clk(clk), .rst_n(rst_n), .req(req),
    .imm(imm), .y(y), .acc(acc), .breg(breg), .r_pin(r_pin), .d_pin(d_pin),
    .r_out(ro[2]), .d_out(dq[2]), .r_rd(rr[2]), .status(st[2]), .illegal_port_write(il[2]));

  task automatic chk(input bit ok, input string tag, input int k,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s inst %0d actual %h expected %h", tag, k, act, exp);
    end
  endtask

  function automatic bit wok(int v, int i);
    case (v)
      43: return (i >= 1) && (i <= 3);
      44: return i <= 5;
      45: return i <= 6;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string wtag(int v);
    return (v == 43) ? "R8" : (v == 44) ? "R7" : "R9";
  endfunction

  function automatic logic [31:0] rvec(int k);
    logic [31:0] v;
    for (int i = 0; i < 8; i++) v[i*4 +: 4] = er[k][i];
    return v;
  endfunction

  task automatic check_state(input string tag);
    for (int k = 0; k < 3; k++) begin
      chk(ro[k] == rvec(k), tag, k, ro[k], rvec(k));
      chk(dq[k] == ed[k], tag, k, {16'h0, dq[k]}, {16'h0, ed[k]});
      chk(st[k] == es[k], tag, k, {31'h0, st[k]}, {31'h0, es[k]});
      chk(il[k] == eil[k], "R10", k, {31'h0, il[k]}, {31'h0, eil[k]});
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [3:0] im, input logic [3:0] yy,
                      input logic [3:0] a, input logic [3:0] b, input string tag);
    @(negedge clk);
    req = op; imm = im; y = yy; acc = a; breg = b;
    #1;
    for (int k = 0; k < 3; k++) begin
      logic [3:0] p, e, dv;
      logic       db;
      int ix;
      ix = int'(im[2:0]);
      p = r_pin[ix*4 +: 4];
      e = CM[k] ? (p & er[k][ix]) : (p | er[k][ix]);
      chk(rr[k] == e, "R2", k, {28'h0, rr[k]}, {28'h0, e});
      eil[k] = 1'b0;
      case (op)
        3'd1: ed[k][yy] = 1'b1;
        3'd2: ed[k][yy] = 1'b0;
        3'd3: ed[k][im] = 1'b1;
        3'd4: ed[k][im] = 1'b0;
        3'd5, 3'd6: begin
          if (wok(VR[k], ix)) er[k][ix] = (op == 3'd5) ? a : b;
          else eil[k] = 1'b1;
        end
        3'd7: begin
          db = CM[k] ? (d_pin[yy] & ed[k][yy]) : (d_pin[yy] | ed[k][yy]);
          if (VR[k] == 43 && yy >= 4) db = ed[k][yy];
          dv = {3'b0, db};
          es[k] = dv[0];
        end
        default: ;
      endcase
    end
    @(negedge clk);
    req = 3'd0;
    #1;
    check_state(tag);
    @(negedge clk);
    #1;
    for (int k = 0; k < 3; k++) eil[k] = 1'b0;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++) er[k][i] = CM[k] ? 4'hF : 4'h0;
      ed[k] = CM[k] ? 16'hFFFF : 16'h0000;
      es[k] = 1'b1;
      eil[k] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check_state("R1");

    r_pin = 32'h9C3A_65F0;
    d_pin = 16'hA5C3;
    for (int i = 0; i < 8; i++) begin
      string t;
      t = wtag(44);
      step(3'd5, 4'(i), 4'd0, 4'(i + 3), 4'h0, "R6");
      step(3'd6, 4'(i), 4'd0, 4'h0, ~4'(i), "R6");
      step(3'd5, 4'(i + 8), 4'd0, 4'(5 * i + 1), 4'h0, t);
    end
    for (int p = 0; p < 4; p++) begin
      r_pin = 32'h1234_5678 ^ (32'h3C3C_A5A5 << p);
      for (int i = 0; i < 8; i++) step(3'd0, 4'(i), 4'd0, 4'h0, 4'h0, "R2");
    end
    for (int bit_i = 0; bit_i < 16; bit_i++) begin
      d_pin = 16'h5A96 ^ (16'(bit_i) * 16'h0911);
      step(3'd2, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R4");
      step(3'd7, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R3");
      step(3'd1, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R4");
      step(3'd7, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R11");
      d_pin = ~d_pin;
      step(3'd7, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R3");
      step(3'd4, 4'(bit_i), 4'd0, 4'h0, 4'h0, "R5");
      step(3'd7, 4'd0, 4'(bit_i), 4'h0, 4'h0, "R11");
      step(3'd3, 4'(15 - bit_i), 4'd0, 4'h0, 4'h0, "R5");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule